// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one read or write burst in a synchronous graphics memory whose rows hold 256 columns. A mode-load strobe stores an ordering bit and a 3-bit length code. A command strobe supplies an 8-bit starting column. From the next cycle on, the block emits one column per clock, together with a valid flag and a last flag. Emission stops when the burst completes, when a stop request arrives, or when a new command takes over.

Two orderings are available: sequential and interleaved. Sequential ordering wraps inside the aligned block of the burst length. Interleaved ordering flips the low column bits with the beat index. In the endless full-row mode, the column counts up by one per cycle and wraps from 255 to 0, so it runs until it is stopped. Software can combine these settings to get a decrementing pattern (interleaved, 8 beats, start with low bits 111). It can also get plain binary counting across block edges (full-row, then a stop request). A command is accepted on any cycle, so a new random column can be issued every clock.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, col_valid and col_last are 0. The stored mode after reset is sequential ordering (ilv=0) with length code 000, which is one beat.
- R2: A command sampled on a clock edge makes col_valid high from that edge, with col_out equal to the commanded column (beat 0).
- R3: Length codes map as follows: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full-row burst without end.
- R4: In sequential ordering (ilv=0) with a finite length BL, beat n outputs the start column with its low log2(BL) bits replaced by (start+n) mod BL. The upper bits stay unchanged.
- R5: In interleaved ordering (ilv=1) with a finite length, beat n outputs the start column with its low log2(BL) bits XORed with n. For lengths 1 and 2 this equals the sequential sequence.
- R6: In full-row mode, beat n outputs (start+n) mod 256, and col_last is never raised.
- R7: burst_stop sampled while a burst is active makes col_valid low after that edge. If a command arrives in the same cycle, the command wins.
- R8: A command arriving while a burst is active discards that burst and starts the new one at beat 0 on the next edge. This holds even on consecutive cycles.
- R9: A mode load takes effect only for commands sampled on later edges. The running burst, and a command sampled on the same edge as the load, use the previously stored mode.
- R10: A mode load that carries a reserved length code (100, 101, 110) is ignored, and the stored mode is kept whole.
- R11: col_last is high exactly on the final beat of a finite burst. After that beat, col_valid drops unless a new command was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode load strobe |
| mode_ilv | input | 1 | Ordering bit: 0 sequential, 1 interleaved |
| mode_len | input | 3 | Burst length code |
| cmd_valid | input | 1 | Read/write command strobe |
| cmd_col | input | 8 | Starting column of the command |
| burst_stop | input | 1 | Stop request for the active burst |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | col_out carries a burst beat |
| col_last | output | 1 | Final beat of a finite burst |

## Verification
The bench runs three kinds of start columns, and each one catches a different fault:

- **Block wrap.** Start columns not aligned to the burst length expose a design that lets the carry leak out of the aligned block. Such a design would step into the neighbouring 4- or 8-column group instead of wrapping back.
- **Interleave patterns.** The 8-beat interleaved starts at low bits 111 and 000 must give the exact decrement and increment orders. A design that adds where it should XOR produces mixed orders for those starts.
- **Full-row wrap.** Full-row bursts started near column 255 must wrap through 0 without raising col_last.

The bench also targets interactions between controls, where a faulty design would show these symptoms:

| Corner case | Symptom of a faulty design |
|---|---|
| Stop and command in the same cycle | Goes idle when it should restart |
| Mode load during a burst | Changes length mid-burst |
| Reserved length code loaded | Silently changes length |
| Commands on every cycle | Keeps counting the old burst when each one should restart at beat 0 |

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int COL_W   = 8;
    localparam int LEN_W   = 3;
    localparam int BEAT_W  = COL_W;

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic [LEN_W-1:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_FULL = 3'b111
    } blen_e;

    typedef struct packed {
        logic  ilv;
        blen_e len;
    } mode_t;

    typedef struct packed {
        logic              act;
        col_t              start;
        logic [BEAT_W-1:0] beat;
        mode_t             mode;
    } burst_t;

    localparam mode_t MODE_RST = '{ilv: 1'b0, len: BLEN_1};

    function automatic logic len_code_ok(input logic [LEN_W-1:0] code);
        case (code)
            3'b000, 3'b001, 3'b010, 3'b011, 3'b111: len_code_ok = 1'b1;
            default:                                len_code_ok = 1'b0;
        endcase
    endfunction

    function automatic logic len_is_full(input blen_e len);
        len_is_full = (len == BLEN_FULL);
    endfunction

    // Low-bit mask of the aligned block, equal to BL-1 for finite lengths.
    function automatic col_t len_mask(input blen_e len);
        case (len)
            BLEN_1:  len_mask = col_t'(0);
            BLEN_2:  len_mask = col_t'(1);
            BLEN_4:  len_mask = col_t'(3);
            BLEN_8:  len_mask = col_t'(7);
            default: len_mask = '1;
        endcase
    endfunction

endpackage

// File: rtl/bsq_mode_reg.sv
module bsq_mode_reg
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             ilv_in,
    input  logic [LEN_W-1:0] len_in,
    output mode_t            mode_q
);

    logic accept;

    assign accept = wr && len_code_ok(len_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
        end else if (accept) begin
            mode_q.ilv <= ilv_in;
            mode_q.len <= blen_e'(len_in);
        end
    end

endmodule

// File: rtl/bsq_beat_ctrl.sv
module bsq_beat_ctrl
    import burst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_t  mode_cur,
    input  logic   cmd_valid,
    input  col_t   cmd_col,
    input  logic   stop,
    output burst_t st_q,
    output logic   final_beat,
    output logic   full_mode
);

    col_t   mask;
    burst_t st_d;

    assign mask       = len_mask(st_q.mode.len);
    assign full_mode  = len_is_full(st_q.mode.len);
    assign final_beat = st_q.act && !full_mode && (st_q.beat == mask);

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            st_d.act   = 1'b1;
            st_d.start = cmd_col;
            st_d.beat  = '0;
            st_d.mode  = mode_cur;
        end else if (st_q.act) begin
            if (stop || final_beat) begin
                st_d.act = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{act: 1'b0, start: '0, beat: '0, mode: MODE_RST};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
    import burst_seq_pkg::*;
(
    input  burst_t st,
    input  logic   full_mode,
    output col_t   col
);

    col_t mask;
    col_t sum;

    assign mask = len_mask(st.mode.len);
    assign sum  = st.start + col_t'(st.beat);

    // Per bit: inside the aligned block the bit counts or flips, outside it holds.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (full_mode) begin
                col[i] = sum[i];
            end else if (mask[i]) begin
                col[i] = st.mode.ilv ? (st.start[i] ^ st.beat[i]) : sum[i];
            end else begin
                col[i] = st.start[i];
            end
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  logic             mode_ilv,
    input  logic [LEN_W-1:0] mode_len,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);

    mode_t  mode_q;
    burst_t st_q;
    logic   final_beat;
    logic   full_mode;
    col_t   col_calc;

    bsq_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr     (mode_wr),
        .ilv_in (mode_ilv),
        .len_in (mode_len),
        .mode_q (mode_q)
    );

    bsq_beat_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_cur   (mode_q),
        .cmd_valid  (cmd_valid),
        .cmd_col    (cmd_col),
        .stop       (burst_stop),
        .st_q       (st_q),
        .final_beat (final_beat),
        .full_mode  (full_mode)
    );

    bsq_addr_gen u_addr (
        .st        (st_q),
        .full_mode (full_mode),
        .col       (col_calc)
    );

    assign col_out   = col_calc;
    assign col_valid = st_q.act;
    assign col_last  = final_beat;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
    import burst_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [7:0] cmd_col,
    input logic       burst_stop,
    input logic [7:0] col_out,
    input logic       col_valid,
    input logic       col_last,
    input logic       full_mode
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!col_valid && !col_last));

    // R2
    cmd_start_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (col_valid && col_out == $past(cmd_col)));

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (col_valid && burst_stop && !cmd_valid) |=> !col_valid);

    // R11
    last_end_chk: assert property (@(posedge clk) disable iff (rst)
        (col_last && !cmd_valid) |=> !col_valid);

    // R11
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    // R6
    full_step_chk: assert property (@(posedge clk) disable iff (rst)
        (col_valid && full_mode && !cmd_valid && !burst_stop)
        |=> (col_valid && col_out == 8'($past(col_out) + 8'd1)));

endmodule

bind burst_col_seq burst_col_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .burst_stop (burst_stop),
    .col_out    (col_out),
    .col_valid  (col_valid),
    .col_last   (col_last),
    .full_mode  (full_mode)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_wr;
    logic       mode_ilv;
    logic [2:0] mode_len;
    logic       cmd_valid;
    logic [7:0] cmd_col;
    logic       burst_stop;
    logic [7:0] col_out;
    logic       col_valid;
    logic       col_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // reference state
    logic       m_ilv;
    logic [2:0] m_len;
    logic       r_act;
    logic [7:0] r_start;
    logic [7:0] r_n;
    logic       r_ilv;
    logic [2:0] r_len;

    always #2.5 clk = ~clk;

    burst_col_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_ilv   (mode_ilv),
        .mode_len   (mode_len),
        .cmd_valid  (cmd_valid),
        .cmd_col    (cmd_col),
        .burst_stop (burst_stop),
        .col_out    (col_out),
        .col_valid  (col_valid),
        .col_last   (col_last)
    );

    function automatic int bl_of(input logic [2:0] c);
        case (c)
            3'b000:  return 1;
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 256;
        endcase
    endfunction

    function automatic bit code_valid(input logic [2:0] c);
        return (c <= 3'b011) || (c == 3'b111);
    endfunction

    function automatic logic [7:0] exp_col();
        int bl = bl_of(r_len);
        logic [7:0] m = 8'(bl - 1);
        if (r_len == 3'b111) return 8'(r_start + r_n);
        if (r_ilv)           return r_start ^ r_n;
        return (r_start & ~m) | (8'(r_start + r_n) & m);
    endfunction

    function automatic bit exp_last();
        return r_act && (r_len != 3'b111) && (int'(r_n) == bl_of(r_len) - 1);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        if (cmd_valid) begin
            r_act = 1; r_start = cmd_col; r_n = 0; r_ilv = m_ilv; r_len = m_len;
        end else if (r_act) begin
            if (burst_stop || exp_last()) r_act = 0;
            else r_n = r_n + 8'd1;
        end
        if (mode_wr && code_valid(mode_len)) begin
            m_ilv = mode_ilv; m_len = mode_len;
        end
    endtask

    // one clock: drive at negedge, model at edge, compare at next negedge
    task automatic cyc(input string tag);
        string t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        mode_wr = 0; cmd_valid = 0; burst_stop = 0;
        if (tag != "") t = tag;
        else if (r_len == 3'b111) t = "R6";
        else if (r_ilv) t = "R5";
        else t = "R4";
        check(tag != "" ? tag : "R11", "valid", col_valid, r_act);
        check(tag != "" ? tag : "R11", "last", col_last, exp_last());
        if (r_act) check(t, "col", col_out, exp_col());
    endtask

    task automatic set_mode(input logic ilv, input logic [2:0] len);
        mode_wr = 1; mode_ilv = ilv; mode_len = len;
    endtask

    task automatic issue(input logic [7:0] c);
        cmd_valid = 1; cmd_col = c;
    endtask

    task automatic run(input int k, input string tag);
        for (int i = 0; i < k; i++) cyc(tag);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; mode_wr = 0; mode_ilv = 0; mode_len = 0;
        cmd_valid = 0; cmd_col = 0; burst_stop = 0;
        m_ilv = 0; m_len = 0; r_act = 0; r_start = 0; r_n = 0; r_ilv = 0; r_len = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "valid in reset", col_valid, 0);
        check("R1", "last in reset", col_last, 0);
        rst = 0;
        cyc("R1");
        // R1: default mode gives one beat
        issue(8'h45); cyc("R2"); cyc("R1");

        // R3 / R4: sequential BL4 from unaligned start wraps inside block
        set_mode(0, 3'b010); cyc("R3");
        issue(8'h16); run(5, "R4");
        set_mode(0, 3'b011); cyc("R3");
        issue(8'hFD); run(9, "R4");

        // R5: interleaved BL8 decrement and increment patterns
        set_mode(1, 3'b011); cyc("R3");
        issue(8'h2F); run(9, "R5");
        issue(8'h20); run(9, "R5");
        // R5: interleaved BL2 equals sequential
        set_mode(1, 3'b001); cyc("R3");
        issue(8'h81); run(3, "R5");

        // R6 / R7: full row from 3, stop after eight beats
        set_mode(0, 3'b111); cyc("R3");
        issue(8'h03); run(8, "R6");
        burst_stop = 1; cyc("R7"); cyc("R7");
        // R6: wrap 255 -> 0
        issue(8'hFE); run(6, "R6");
        // R7: stop and command together, command wins
        burst_stop = 1; issue(8'h10); cyc("R7"); run(2, "R6");
        burst_stop = 1; cyc("R7");

        // R9: mode load mid-burst does not alter it
        set_mode(0, 3'b011); cyc("R9");
        issue(8'h40); cyc("R9");
        set_mode(0, 3'b001); run(9, "R9");
        set_mode(0, 3'b010); issue(8'h51); run(4, "R9");
        issue(8'h52); run(5, "R9");

        // R10: reserved codes ignored
        set_mode(1, 3'b101); cyc("R10");
        set_mode(1, 3'b100); cyc("R10");
        issue(8'h33); run(5, "R10");

        // R8: commands every cycle
        for (int i = 0; i < 6; i++) begin
            issue(8'(i * 37 + 5)); cyc("R8");
        end
        run(4, "R8");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int p = $urandom_range(0, 99);
            if ($urandom_range(0, 99) < 8) begin
                logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111, 3'b110};
                set_mode(1'($urandom_range(0, 1)), codes[$urandom_range(0, 5)]);
            end
            if (p < 14) issue(8'($urandom_range(0, 255)));
            if ($urandom_range(0, 99) < 4) burst_stop = 1;
            cyc("");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule